// File: doc/BRIEF.md
# Integer ALU with condition flags

This block is the data-processing arithmetic and logic unit of a 32-bit RISC integer pipeline. Each cycle it takes a first operand, a second operand that has already left the barrel shifter, the shifter's carry-out, an operation code, a flag-update enable and the current condition flags. From these it forms the result word and the next values of the negative, zero, carry and overflow flags.

Arithmetic operations (add, subtract, reverse subtract) take carry and overflow from a single adder. The logical family (and, or, or-not, bit-clear, exclusive-or, move, move-not) and the move-top operation keep overflow. They take carry from the shifter for a register operand. For an immediate operand, carry is bit 31 of the operand if the immediate was rotated, and is otherwise kept. Result and flags are registered, so they appear one clock after the inputs.

The flag nibble mirrors bits 31..28 of a status word: bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.

Top module: `nzcv_alu`

## Requirements
- R1: `result` and `flags_out` show the outcome of the inputs sampled at the previous rising clock edge; a synchronous active-high `rst` clears both to zero.
- R2: When flags are updated, N (bit 3) equals result bit 31 and Z (bit 2) is 1 exactly when the 32-bit result is zero.
- R3: Opcode 8 (add) gives op_a + op_b; C is the carry out of bit 31 and V is the signed overflow of the sum.
- R4: Opcode 9 (subtract) gives op_a - op_b, formed as op_a + ~op_b + 1; C is 1 when no borrow occurs (op_a >= op_b unsigned), and V is the signed overflow.
- R5: Opcode 10 (reverse subtract) gives op_b - op_a; C is 1 when op_b >= op_a unsigned, and V is the signed overflow of op_b - op_a.
- R6: Logical results by opcode: 0 and, 1 or, 2 op_a | ~op_b, 3 op_a & ~op_b, 4 op_b, 5 ~op_b, 6 exclusive-or.
- R7: For opcodes 0 to 7 with `src_imm` low, C takes `shift_cout` and V keeps its old value.
- R8: For opcodes 0 to 7 with `src_imm` high, C becomes op_b bit 31 when `imm_rot` is high and keeps its old value when `imm_rot` is low; V keeps its old value.
- R9: Opcode 7 (move-top) gives {op_b[15:0], op_a[15:0]}.
- R10: With `set_flags` low, `flags_out` equals `flags_in` for every opcode.
- R11: Opcodes 11 to 15 are unassigned: the result is zero and the flags equal `flags_in`, whatever `set_flags` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, after the shifter |
| op_code | input | 4 | Operation selector |
| set_flags | input | 1 | Update the flags when high |
| src_imm | input | 1 | Second operand came from an immediate |
| imm_rot | input | 1 | The immediate was rotated |
| shift_cout | input | 1 | Carry-out of the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Registered result |
| flags_out | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
The carry rule and the zero/negative rule fall in the same cycle, and they collide at the word boundaries. An add that wraps to zero must give Z=1 and C=1 together. A subtract of equal operands must give Z=1 with C=1 in the no-borrow sense. An overflowing add into bit 31 must give N=1 and V=1 together. These cases are driven as directed vectors and followed by several thousand random ones with mixed opcodes, immediate and rotation settings, and flag-update enables. Each cycle is judged against a behavioural model that works in 64-bit signed and unsigned integers, not with an adder.

// File: rtl/nzcv_alu_pkg.sv
package nzcv_alu_pkg;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int NFLAGS = 4;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_ORR = 4'd1,
    OP_ORN = 4'd2,
    OP_BIC = 4'd3,
    OP_MOV = 4'd4,
    OP_MVN = 4'd5,
    OP_EOR = 4'd6,
    OP_MVT = 4'd7,
    OP_ADD = 4'd8,
    OP_SUB = 4'd9,
    OP_RSB = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_NONE  = 2'd2
  } op_class_e;

  typedef enum logic [1:0] {
    AM_ADD = 2'd0,
    AM_SUB = 2'd1,
    AM_RSB = 2'd2
  } arith_mode_e;

  function automatic op_class_e classify(input logic [3:0] code);
    if (code <= 4'd7)       return CLS_LOGIC;
    else if (code <= 4'd10) return CLS_ARITH;
    else                    return CLS_NONE;
  endfunction

endpackage

// File: rtl/nzcv_alu_addsub.sv
module nzcv_alu_addsub
  import nzcv_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  arith_mode_e      mode,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);
  logic [WIDTH-1:0] x, y;
  logic             cin;
  logic [WIDTH:0]   full;

  always_comb begin
    x   = a;
    y   = b;
    cin = 1'b0;
    case (mode)
      AM_SUB: begin
        y   = ~b;
        cin = 1'b1;
      end
      AM_RSB: begin
        x   = b;
        y   = ~a;
        cin = 1'b1;
      end
      default: ;
    endcase
    full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  end

  assign sum   = full[WIDTH-1:0];
  assign carry = full[WIDTH];
  assign ovf   = (x[WIDTH-1] == y[WIDTH-1]) && (full[WIDTH-1] != x[WIDTH-1]);

endmodule

// File: rtl/nzcv_alu_logic.sv
module nzcv_alu_logic
  import nzcv_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       sel,
  output logic [WIDTH-1:0] res
);
  localparam int HALF = WIDTH / 2;

  always_comb begin
    case (sel)
      3'd0:    res = a & b;
      3'd1:    res = a | b;
      3'd2:    res = a | ~b;
      3'd3:    res = a & ~b;
      3'd4:    res = b;
      3'd5:    res = ~b;
      3'd6:    res = a ^ b;
      default: res = {b[HALF-1:0], a[HALF-1:0]};
    endcase
  end

endmodule

// File: rtl/nzcv_alu_flags.sv
module nzcv_alu_flags
  import nzcv_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  op_class_e         cls,
  input  logic [WIDTH-1:0]  res,
  input  logic              op_b_msb,
  input  logic              add_carry,
  input  logic              add_ovf,
  input  logic              shift_cout,
  input  logic              src_imm,
  input  logic              imm_rot,
  input  logic              set_flags,
  input  logic [NFLAGS-1:0] flags_in,
  output logic [NFLAGS-1:0] flags_next
);
  logic c_new, v_new;

  always_comb begin
    if (cls == CLS_ARITH) begin
      c_new = add_carry;
      v_new = add_ovf;
    end else begin
      v_new = flags_in[FLAG_V];
      if (!src_imm)     c_new = shift_cout;
      else if (imm_rot) c_new = op_b_msb;
      else              c_new = flags_in[FLAG_C];
    end

    if (!set_flags || cls == CLS_NONE) begin
      flags_next = flags_in;
    end else begin
      flags_next         = '0;
      flags_next[FLAG_N] = res[WIDTH-1];
      flags_next[FLAG_Z] = (res == '0);
      flags_next[FLAG_C] = c_new;
      flags_next[FLAG_V] = v_new;
    end
  end

endmodule

// File: rtl/nzcv_alu.sv
module nzcv_alu
  import nzcv_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic [3:0]        op_code,
  input  logic              set_flags,
  input  logic              src_imm,
  input  logic              imm_rot,
  input  logic              shift_cout,
  input  logic [NFLAGS-1:0] flags_in,
  output logic [WIDTH-1:0]  result,
  output logic [NFLAGS-1:0] flags_out
);
  op_class_e         cls;
  arith_mode_e       amode;
  logic [WIDTH-1:0]  add_sum, logic_res, res_d;
  logic              add_c, add_v;
  logic [NFLAGS-1:0] flags_d;

  assign cls = classify(op_code);

  always_comb begin
    case (op_code)
      OP_SUB:  amode = AM_SUB;
      OP_RSB:  amode = AM_RSB;
      default: amode = AM_ADD;
    endcase
  end

  nzcv_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a     (op_a),
    .b     (op_b),
    .mode  (amode),
    .sum   (add_sum),
    .carry (add_c),
    .ovf   (add_v)
  );

  nzcv_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a   (op_a),
    .b   (op_b),
    .sel (op_code[2:0]),
    .res (logic_res)
  );

  always_comb begin
    case (cls)
      CLS_ARITH: res_d = add_sum;
      CLS_LOGIC: res_d = logic_res;
      default:   res_d = '0;
    endcase
  end

  nzcv_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .cls        (cls),
    .res        (res_d),
    .op_b_msb   (op_b[WIDTH-1]),
    .add_carry  (add_c),
    .add_ovf    (add_v),
    .shift_cout (shift_cout),
    .src_imm    (src_imm),
    .imm_rot    (imm_rot),
    .set_flags  (set_flags),
    .flags_in   (flags_in),
    .flags_next (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flags_out <= '0;
    end else begin
      result    <= res_d;
      flags_out <= flags_d;
    end
  end

endmodule

// File: rtl/nzcv_alu_chk.sv
module nzcv_alu_chk
  import nzcv_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [WIDTH-1:0]  op_a,
  input logic [WIDTH-1:0]  op_b,
  input logic [3:0]        op_code,
  input logic              set_flags,
  input logic              src_imm,
  input logic              imm_rot,
  input logic              shift_cout,
  input logic [NFLAGS-1:0] flags_in,
  input logic [WIDTH-1:0]  result,
  input logic [NFLAGS-1:0] flags_out
);
  localparam int HALF = WIDTH / 2;

  logic seen;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R1: outputs cleared after a reset edge
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      a_r1_reset_clear: assert (result == '0 && flags_out == '0)
        else $error("a_r1_reset_clear");
    end
  end

  // R2
  a_r2_nz_follow: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(set_flags) && $past(op_code) <= 4'd10) |->
      (flags_out[FLAG_Z] == (result == '0) && flags_out[FLAG_N] == result[WIDTH-1]));

  // R7 / R8: logic ops never touch V
  a_r7_logic_keeps_v: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(op_code) <= 4'd7) |-> (flags_out[FLAG_V] == $past(flags_in[FLAG_V])));

  // R9
  a_r9_mvt_low_kept: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(op_code) == 4'd7) |->
      (result == {$past(op_b[HALF-1:0]), $past(op_a[HALF-1:0])}));

  // R10
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(set_flags)) |-> (flags_out == $past(flags_in)));

  // R11
  a_r11_unassigned: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(op_code) > 4'd10) |-> (result == '0 && flags_out == $past(flags_in)));

endmodule

bind nzcv_alu nzcv_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_nzcv_alu.sv
module test_nzcv_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] op_a, op_b;
  logic [3:0]  op_code;
  logic        set_flags, src_imm, imm_rot, shift_cout;
  logic [3:0]  flags_in;
  logic [31:0] result;
  logic [3:0]  flags_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nzcv_alu i_nzcv_alu (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_code(op_code),
    .set_flags(set_flags), .src_imm(src_imm), .imm_rot(imm_rot),
    .shift_cout(shift_cout), .flags_in(flags_in),
    .result(result), .flags_out(flags_out)
  );

  function automatic string tag_of(input logic [3:0] op, input logic imm, input logic sf);
    if (op > 4'd10)  return "R11";
    if (!sf)         return "R10";
    if (op == 4'd8)  return "R3";
    if (op == 4'd9)  return "R4";
    if (op == 4'd10) return "R5";
    if (imm)         return "R8";
    if (op == 4'd7)  return "R9";
    return "R7";
  endfunction

  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                       input logic sf, input logic imm, input logic rot, input logic sh,
                       input logic [3:0] fin, output logic [31:0] r, output logic [3:0] f);
    longint sa, sb, s;
    logic c, v;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    s  = 0;
    c  = fin[1];
    v  = fin[0];
    r  = 32'd0;
    case (op)
      4'd0: r = a & b;
      4'd1: r = a | b;
      4'd2: r = a | ~b;
      4'd3: r = a & ~b;
      4'd4: r = b;
      4'd5: r = ~b;
      4'd6: r = a ^ b;
      4'd7: r = {b[15:0], a[15:0]};
      4'd8: begin r = a + b; c = ({32'd0, a} + {32'd0, b}) > 64'hFFFF_FFFF; s = sa + sb; end
      4'd9: begin r = a - b; c = (a >= b); s = sa - sb; end
      4'd10: begin r = b - a; c = (b >= a); s = sb - sa; end
      default: r = 32'd0;
    endcase
    if (op >= 4'd8 && op <= 4'd10) v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    else if (op <= 4'd7) c = imm ? (rot ? b[31] : fin[1]) : sh;
    if (!sf || op > 4'd10) f = fin;
    else f = {r[31], r == 32'd0, c, v};
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                     input logic sf, input logic imm, input logic rot, input logic sh,
                     input logic [3:0] fin, input string tag);
    logic [31:0] er;
    logic [3:0]  ef;
    @(negedge clk);
    op_a = a; op_b = b; op_code = op; set_flags = sf;
    src_imm = imm; imm_rot = rot; shift_cout = sh; flags_in = fin;
    model(a, b, op, sf, imm, rot, sh, fin, er, ef);
    @(negedge clk);
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s result op=%0d actual=%h expected=%h", tag, op, result, er);
    end
    checks++;
    if (flags_out !== ef) begin
      errors++;
      $display("FAIL %s flags op=%0d actual=%b expected=%b", tag, op, flags_out, ef);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    op_a = 32'hFFFF_FFFF; op_b = 32'h1234_5678; op_code = 4'd8;
    set_flags = 1'b1; src_imm = 1'b0; imm_rot = 1'b0; shift_cout = 1'b1; flags_in = 4'hF;
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 32'd0 || flags_out !== 4'd0) begin
      errors++;
      $display("FAIL R1 reset actual=%h/%b expected=0/0000", result, flags_out);
    end
    rst = 1'b0;

    // R2 with R3: wrap to zero, Z and C together
    run(32'hFFFF_FFFF, 32'h1, 4'd8, 1, 0, 0, 0, 4'h0, "R2 R3 wrap");
    // R3: signed overflow into bit 31, N and V together
    run(32'h7FFF_FFFF, 32'h1, 4'd8, 1, 0, 0, 0, 4'h0, "R2 R3 ovf");
    run(32'h8000_0000, 32'h8000_0000, 4'd8, 1, 0, 0, 0, 4'h0, "R3 neg ovf");
    // R4
    run(32'h1234, 32'h1234, 4'd9, 1, 0, 0, 0, 4'h0, "R2 R4 equal");
    run(32'h0, 32'h1, 4'd9, 1, 0, 0, 0, 4'h0, "R4 borrow");
    run(32'h8000_0000, 32'h1, 4'd9, 1, 0, 0, 0, 4'h0, "R4 ovf");
    // R5
    run(32'h5, 32'h3, 4'd10, 1, 0, 0, 0, 4'h0, "R5 borrow");
    run(32'h3, 32'h5, 4'd10, 1, 0, 0, 0, 4'hF, "R5 plain");
    // R6 / R7
    for (int k = 0; k < 7; k++)
      run(32'hF0F0_1234, 32'h0FF0_8765, 4'(k), 1, 0, 0, k[0], 4'h5, "R6 R7 logic");
    run(32'h0, 32'h0, 4'd0, 1, 0, 0, 1, 4'h1, "R2 R7 zero");
    // R8
    run(32'h1, 32'h8000_00FF, 4'd4, 1, 1, 1, 0, 4'h0, "R8 rotated");
    run(32'h1, 32'h0000_00FF, 4'd4, 1, 1, 1, 1, 4'h2, "R8 rotated low");
    run(32'h1, 32'h8000_00FF, 4'd4, 1, 1, 0, 0, 4'h2, "R8 unrotated");
    // R9
    run(32'hAAAA_5555, 32'h1234_BEEF, 4'd7, 1, 0, 0, 0, 4'h0, "R9 move-top");
    // R10
    run(32'hFFFF_FFFF, 32'h1, 4'd8, 0, 0, 0, 1, 4'h9, "R10 hold add");
    run(32'h0, 32'h0, 4'd0, 0, 0, 0, 1, 4'h6, "R10 hold logic");
    // R11
    for (int k = 11; k < 16; k++)
      run(32'hDEAD_BEEF, 32'h1, 4'(k), 1, 1, 1, 1, 4'(k), "R11 unassigned");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ra, rb;
      logic [3:0]  rop, rf;
      logic        rsf, rimm, rrot, rsh;
      ra = $urandom; rb = $urandom;
      if (n % 5 == 0) rb = ra;
      if (n % 7 == 0) ra = 32'h8000_0000;
      rop = 4'($urandom_range(0, 15));
      if (n % 3 != 0 && rop > 4'd10) rop = 4'd8 + 4'(n % 3);
      rf = 4'($urandom);
      rsf = ($urandom_range(0, 3) != 0);
      rimm = 1'($urandom); rrot = 1'($urandom); rsh = 1'($urandom);
      run(ra, rb, rop, rsf, rimm, rrot, rsh, rf, tag_of(rop, rimm, rsf));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule